// File: doc/BRIEF.md
# VLAN Membership Table Command Engine

This block keeps a small table of VLAN entries. Each entry holds a valid bit, a 12-bit VLAN ID and a 10-bit port member mask. Software reaches the table through two words on a simple 32-bit register bus:

- a command word, which carries an operation code, an active flag and the operation's arguments;
- a data word, which carries the member mask and a valid flag.

Writing the command word with the active flag set starts a background operation. The operation walks the table one entry per cycle. It can empty the whole table, add or replace an entry, remove the entry for one VLAN ID, or strip one port from every entry's mask.

The active flag reads back high while the operation runs. A separate full flag records that a load found neither a matching entry nor a free slot. Software writes the data word first, then the command word, and waits for the active flag to read low before it issues the next command.

A lookup port serves the forwarding logic. It takes a VLAN ID request and returns a hit flag and the member mask on the following cycle.

Top module: `vlan_cmd_engine`

## Requirements
- R1: The command word (bus address 0x0) has these fields: op in bits 2:0, active in bit 3, full in bit 4, port in bits 11:8, VLAN ID in bits 27:16, priority in bits 30:28 and priority enable in bit 31. A read returns the stored op, port, VLAN ID, priority and enable fields, with the live active and full flags. All other bits read as zero. A write with bit 3 clear only stores the fields.
- R2: The data word (bus address 0x4) holds the member mask in bits 9:0 and the valid flag in bit 11. All other bits read as zero.
- R3: Flush (op 1) clears every entry. Active stays high for exactly 16 cycles after the accepting edge.
- R4: Load (op 2) writes the data mask under the command's VLAN ID into the lowest free slot. Active stays high for 17 cycles. If the data valid flag is clear, a load leaves the table unchanged.
- R5: A load whose VLAN ID is already present overwrites that entry's mask and does not use another slot. No two valid entries ever share a VLAN ID.
- R6: A load that finds neither a match nor a free slot sets the full flag and leaves the table unchanged. The full flag clears when the next command starts.
- R7: Purge (op 3) invalidates only the entry whose VLAN ID matches. Active stays high for 16 cycles.
- R8: Remove-port (op 4) clears bit `port` of the mask of every valid entry. A port number of 10 or more changes nothing.
- R9: A command-word write while active is high is ignored.
- R10: One cycle after a lookup request, the hit flag and mask report the entry for the requested VLAN ID. A miss returns hit 0 and mask 0. The outputs hold between requests.
- R11: After reset the table is empty, both words read zero and active is low.
- R12: Op 0 and the undefined ops 5 to 7 hold active for one cycle and leave the table unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | 4 | Register byte address |
| bus_wdata_i | input | 32 | Register write data |
| bus_rdata_o | output | 32 | Register read data for bus_addr_i, combinational |
| lkp_req_i | input | 1 | Lookup request |
| lkp_vid_i | input | 12 | VLAN ID to look up |
| lkp_hit_o | output | 1 | A valid entry matched the requested VLAN ID |
| lkp_mask_o | output | 10 | Member mask of the matching entry |

## Verification
The assertions rely on software following the handshake:

- The data word is written before the command word.
- A new command is issued only after active reads low.
- Loads never create a second entry with the same VLAN ID.

The stimulus keeps to this handshake. Every command goes through a task that polls the active flag until it reads low. The single intentional break is a command-word write placed inside a running flush, which exercises the ignore rule. The lookup requests are spaced so that each result is compared on the cycle after its request.

// File: rtl/vlan_cmd_pkg.sv
package vlan_cmd_pkg;
  localparam int VID_W  = 12;
  localparam int MASK_W = 10;
  localparam int PORT_W = 4;
  localparam int PRIO_W = 3;

  typedef enum logic [2:0] {
    OP_NOP    = 3'd0,
    OP_FLUSH  = 3'd1,
    OP_LOAD   = 3'd2,
    OP_PURGE  = 3'd3,
    OP_RMPORT = 3'd4
  } vlan_op_e;

  typedef struct packed {
    logic              valid;
    logic [VID_W-1:0]  vid;
    logic [MASK_W-1:0] mask;
  } vlan_ent_t;
endpackage

// File: rtl/vlan_tbl_store.sv
module vlan_tbl_store
  import vlan_cmd_pkg::*;
#(
  parameter int ENTRIES = 16,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  vlan_ent_t         wr_ent_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output vlan_ent_t         rd_ent_o,
  input  logic              lkp_req_i,
  input  logic [VID_W-1:0]  lkp_vid_i,
  output logic              lkp_hit_o,
  output logic [MASK_W-1:0] lkp_mask_o
);
  vlan_ent_t         tbl_q [ENTRIES];
  logic [ENTRIES-1:0] hit_vec;
  logic [MASK_W-1:0]  mask_or;
  logic               hit_q;
  logic [MASK_W-1:0]  mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < ENTRIES; i++) tbl_q[i] <= '0;
    end else if (wr_en_i) begin
      tbl_q[wr_idx_i] <= wr_ent_i;
    end
  end

  assign rd_ent_o = tbl_q[rd_idx_i];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_match
    assign hit_vec[g] = tbl_q[g].valid && (tbl_q[g].vid == lkp_vid_i);
  end

  always_comb begin
    mask_or = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (hit_vec[i]) mask_or = mask_or | tbl_q[i].mask;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hit_q  <= 1'b0;
      mask_q <= '0;
    end else if (lkp_req_i) begin
      hit_q  <= |hit_vec;
      mask_q <= mask_or;
    end
  end

  assign lkp_hit_o  = hit_q;
  assign lkp_mask_o = mask_q;

  AST_UNIQUE_VID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(hit_vec) <= 1); // R5
  AST_MISS_ZERO_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lkp_hit_o |-> (lkp_mask_o == '0)); // R10
  AST_LKP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lkp_req_i |=> $stable(lkp_hit_o) && $stable(lkp_mask_o)); // R10
endmodule

// File: rtl/vlan_cmd_fsm.sv
module vlan_cmd_fsm
  import vlan_cmd_pkg::*;
#(
  parameter int ENTRIES = 16,
  localparam int IDX_W = $clog2(ENTRIES),
  localparam int CNT_W = $clog2(ENTRIES + 3)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [2:0]        op_i,
  input  logic [VID_W-1:0]  vid_i,
  input  logic [PORT_W-1:0] port_i,
  input  logic [MASK_W-1:0] mask_i,
  input  logic              dvalid_i,
  output logic [IDX_W-1:0]  rd_idx_o,
  input  vlan_ent_t         rd_ent_i,
  output logic              wr_en_o,
  output logic [IDX_W-1:0]  wr_idx_o,
  output vlan_ent_t         wr_ent_o,
  output logic              active_o,
  output logic              full_o
);
  typedef enum logic [1:0] {ST_IDLE, ST_SCAN, ST_COMMIT} st_e;

  st_e               st_q;
  logic [2:0]        op_q;
  logic [VID_W-1:0]  vid_q;
  logic [PORT_W-1:0] port_q;
  logic [MASK_W-1:0] mask_q;
  logic              dvalid_q;
  logic [IDX_W-1:0]  idx_q;
  logic              match_seen_q, free_seen_q;
  logic [IDX_W-1:0]  match_idx_q, free_idx_q;
  logic              full_q;
  logic              vid_eq, last_idx;
  logic [CNT_W-1:0]  busy_cnt_q;

  assign vid_eq   = rd_ent_i.valid && (rd_ent_i.vid == vid_q);
  assign last_idx = (idx_q == IDX_W'(ENTRIES - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q         <= ST_IDLE;
      op_q         <= '0;
      vid_q        <= '0;
      port_q       <= '0;
      mask_q       <= '0;
      dvalid_q     <= 1'b0;
      idx_q        <= '0;
      match_seen_q <= 1'b0;
      free_seen_q  <= 1'b0;
      match_idx_q  <= '0;
      free_idx_q   <= '0;
      full_q       <= 1'b0;
    end else begin
      case (st_q)
        ST_IDLE: if (start_i) begin
          st_q         <= ST_SCAN;
          op_q         <= op_i;
          vid_q        <= vid_i;
          port_q       <= port_i;
          mask_q       <= mask_i;
          dvalid_q     <= dvalid_i;
          idx_q        <= '0;
          match_seen_q <= 1'b0;
          free_seen_q  <= 1'b0;
          full_q       <= 1'b0;
        end
        ST_SCAN: begin
          if (op_q == OP_LOAD) begin
            if (vid_eq && !match_seen_q) begin
              match_seen_q <= 1'b1;
              match_idx_q  <= idx_q;
            end
            if (!rd_ent_i.valid && !free_seen_q) begin
              free_seen_q <= 1'b1;
              free_idx_q  <= idx_q;
            end
          end
          if (!(op_q inside {OP_FLUSH, OP_LOAD, OP_PURGE, OP_RMPORT})) begin
            st_q <= ST_IDLE;
          end else if (last_idx) begin
            st_q <= (op_q == OP_LOAD) ? ST_COMMIT : ST_IDLE;
          end else begin
            idx_q <= idx_q + 1'b1;
          end
        end
        ST_COMMIT: begin
          if (dvalid_q && !match_seen_q && !free_seen_q) full_q <= 1'b1;
          st_q <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // single table write port shared by all operations
  always_comb begin
    wr_en_o  = 1'b0;
    wr_idx_o = idx_q;
    wr_ent_o = rd_ent_i;
    if (st_q == ST_SCAN) begin
      case (op_q)
        OP_FLUSH: begin
          wr_en_o        = 1'b1;
          wr_ent_o.valid = 1'b0;
        end
        OP_PURGE: if (vid_eq) begin
          wr_en_o        = 1'b1;
          wr_ent_o.valid = 1'b0;
        end
        OP_RMPORT: if (rd_ent_i.valid && (32'(port_q) < MASK_W)) begin
          wr_en_o       = 1'b1;
          wr_ent_o.mask = rd_ent_i.mask & ~(MASK_W'(1) << port_q);
        end
        default: ;
      endcase
    end else if (st_q == ST_COMMIT && dvalid_q && (match_seen_q || free_seen_q)) begin
      wr_en_o  = 1'b1;
      wr_idx_o = match_seen_q ? match_idx_q : free_idx_q;
      wr_ent_o = '{valid: 1'b1, vid: vid_q, mask: mask_q};
    end
  end

  assign rd_idx_o = idx_q;
  assign active_o = (st_q != ST_IDLE);
  assign full_o   = full_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        busy_cnt_q <= '0;
    else if (!active_o) busy_cnt_q <= '0;
    else                busy_cnt_q <= busy_cnt_q + 1'b1;
  end

  AST_SCAN_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(busy_cnt_q) <= ENTRIES + 1); // R3
  AST_FULL_ON_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(full_o) |-> (op_q == OP_LOAD)); // R6
  AST_COMMIT_AFTER_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_COMMIT) |-> ($past(idx_q) == IDX_W'(ENTRIES - 1))); // R4
  AST_IDLE_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(active_o) |=> !wr_en_o || active_o); // R12
endmodule

// File: rtl/vlan_cmd_engine.sv
module vlan_cmd_engine
  import vlan_cmd_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int ADDR_W  = 4,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [31:0]       bus_wdata_i,
  output logic [31:0]       bus_rdata_o,
  input  logic              lkp_req_i,
  input  logic [VID_W-1:0]  lkp_vid_i,
  output logic              lkp_hit_o,
  output logic [MASK_W-1:0] lkp_mask_o
);
  localparam logic [ADDR_W-1:0] CMD_ADDR  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] DATA_ADDR = ADDR_W'(4);

  logic [2:0]        op_q;
  logic [PORT_W-1:0] port_q;
  logic [VID_W-1:0]  vid_q;
  logic [PRIO_W-1:0] prio_q;
  logic              prio_en_q;
  logic [MASK_W-1:0] dmask_q;
  logic              dvalid_q;
  logic              active, full;
  logic              cmd_we, cmd_acc, data_we, start;
  logic [IDX_W-1:0]  rd_idx, wr_idx;
  logic              wr_en;
  vlan_ent_t         rd_ent, wr_ent;
  logic              unused_wdata;

  assign cmd_we  = bus_we_i && (bus_addr_i == CMD_ADDR);
  assign data_we = bus_we_i && (bus_addr_i == DATA_ADDR);
  assign cmd_acc = cmd_we && !active;
  assign start   = cmd_acc && bus_wdata_i[3];
  assign unused_wdata = ^{bus_wdata_i[15:12], bus_wdata_i[10]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_q      <= '0;
      port_q    <= '0;
      vid_q     <= '0;
      prio_q    <= '0;
      prio_en_q <= 1'b0;
      dmask_q   <= '0;
      dvalid_q  <= 1'b0;
    end else begin
      if (cmd_acc) begin
        op_q      <= bus_wdata_i[2:0];
        port_q    <= bus_wdata_i[11:8];
        vid_q     <= bus_wdata_i[27:16];
        prio_q    <= bus_wdata_i[30:28];
        prio_en_q <= bus_wdata_i[31];
      end
      if (data_we) begin
        dmask_q  <= bus_wdata_i[9:0];
        dvalid_q <= bus_wdata_i[11];
      end
    end
  end

  always_comb begin
    bus_rdata_o = '0;
    if (bus_addr_i == CMD_ADDR)
      bus_rdata_o = {prio_en_q, prio_q, vid_q, 4'b0, port_q, 3'b0, full, active, op_q};
    else if (bus_addr_i == DATA_ADDR)
      bus_rdata_o = {20'b0, dvalid_q, 1'b0, dmask_q};
  end

  vlan_cmd_fsm #(.ENTRIES(ENTRIES)) fsm_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start),
    .op_i     (bus_wdata_i[2:0]),
    .vid_i    (bus_wdata_i[27:16]),
    .port_i   (bus_wdata_i[11:8]),
    .mask_i   (dmask_q),
    .dvalid_i (dvalid_q),
    .rd_idx_o (rd_idx),
    .rd_ent_i (rd_ent),
    .wr_en_o  (wr_en),
    .wr_idx_o (wr_idx),
    .wr_ent_o (wr_ent),
    .active_o (active),
    .full_o   (full)
  );

  vlan_tbl_store #(.ENTRIES(ENTRIES)) store_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en),
    .wr_idx_i   (wr_idx),
    .wr_ent_i   (wr_ent),
    .rd_idx_i   (rd_idx),
    .rd_ent_o   (rd_ent),
    .lkp_req_i  (lkp_req_i),
    .lkp_vid_i  (lkp_vid_i),
    .lkp_hit_o  (lkp_hit_o),
    .lkp_mask_o (lkp_mask_o)
  );

  AST_BUSY_WRITE_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active && cmd_we) |=> $stable(op_q) && $stable(vid_q) && $stable(port_q)); // R9
  AST_START_RAISES_ACTIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start |=> active); // R1
endmodule

// File: tb/vlan_cmd_engine_tb.sv
`timescale 1ns/1ps
module vlan_cmd_engine_tb_top;
  typedef struct {
    string       tag;
    logic        hit;
    logic [9:0]  mask;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        lkp_req = 1'b0;
  logic [11:0] lkp_vid = '0;
  logic        lkp_hit;
  logic [9:0]  lkp_mask;
  logic        pend_q = 1'b0;
  exp_t        exp_q[$];
  int          n_chk = 0;
  int          n_bad = 0;

  always #2.5 clk = ~clk;

  vlan_cmd_engine dut_i (
    .clk_i(clk), .rst_ni(rst_n), .bus_we_i(bus_we), .bus_addr_i(bus_addr),
    .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata), .lkp_req_i(lkp_req),
    .lkp_vid_i(lkp_vid), .lkp_hit_o(lkp_hit), .lkp_mask_o(lkp_mask)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // monitor: pops one expected lookup result per request
  always @(posedge clk) pend_q <= lkp_req;
  always @(negedge clk) begin
    if (pend_q) begin
      if (exp_q.size() == 0) begin
        n_chk++; n_bad++;
        $display("FAIL R10: lookup result with empty scoreboard, actual %b/%h expected none", lkp_hit, lkp_mask);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check(e.tag, {21'b0, lkp_hit, lkp_mask}, {21'b0, e.hit, e.mask});
      end
    end
  end

  task automatic lookup(input logic [11:0] vid, input logic hit, input logic [9:0] mask, input string tag);
    exp_t e;
    e.tag = tag; e.hit = hit; e.mask = mask;
    exp_q.push_back(e);
    @(negedge clk); lkp_req = 1'b1; lkp_vid = vid;
    @(negedge clk); lkp_req = 1'b0;
  endtask

  task automatic bus_wr(input logic [3:0] addr, input logic [31:0] data);
    @(negedge clk); bus_we = 1'b1; bus_addr = addr; bus_wdata = data;
    @(negedge clk); bus_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] addr, output logic [31:0] data);
    bus_addr = addr; #1; data = bus_rdata;
  endtask

  task automatic run_cmd(input logic [31:0] cmd, input int exp_cycles, input string tag);
    int cnt;
    bus_wr(4'h0, cmd);
    cnt = 0;
    while (bus_rdata[3] && cnt < 100) begin
      cnt++;
      @(negedge clk);
    end
    check(tag, cnt, exp_cycles);
  endtask

  task automatic report;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rd(4'h0, v); check("R11 cmd after reset", v, 32'h0);
    rd(4'h4, v); check("R11 data after reset", v, 32'h0);
    lookup(12'd0, 1'b0, 10'h0, "R11 empty table");

    bus_wr(4'h4, 32'hFFFF_FFFF);
    rd(4'h4, v); check("R2 data field mask", v, 32'h0000_0BFF);

    bus_wr(4'h4, 32'h0000_080F);
    run_cmd(32'h0005_000A, 17, "R4 load active cycles");
    rd(4'h0, v); check("R1 cmd readback", v, 32'h0005_0002);
    lookup(12'd5, 1'b1, 10'h00F, "R10 lookup hit");
    lookup(12'd6, 1'b0, 10'h000, "R10 lookup miss");

    bus_wr(4'h4, 32'h0000_08F0);
    run_cmd(32'h0005_000A, 17, "R5 overwrite load cycles");
    lookup(12'd5, 1'b1, 10'h0F0, "R5 overwrite mask");

    bus_wr(4'h4, 32'h0000_0BFF);
    for (int k = 100; k < 115; k++) run_cmd(32'h0000_000A | (32'(k) << 16), 17, "R4 fill load");
    lookup(12'd114, 1'b1, 10'h3FF, "R5 no extra slot used");

    run_cmd(32'h00C8_000A, 17, "R6 load into full table");
    rd(4'h0, v); check("R6 full flag set", (v >> 4) & 32'h1, 32'h1);
    lookup(12'd200, 1'b0, 10'h000, "R6 rejected vid absent");
    lookup(12'd5, 1'b1, 10'h0F0, "R6 table unchanged");

    bus_wr(4'h4, 32'h0000_0911);
    run_cmd(32'h0005_000A, 17, "R5 overwrite when full");
    rd(4'h0, v); check("R6 full cleared at next start", (v >> 4) & 32'h1, 32'h0);
    lookup(12'd5, 1'b1, 10'h111, "R5 overwrite while full");

    run_cmd(32'h0064_000B, 16, "R7 purge cycles");
    lookup(12'd100, 1'b0, 10'h000, "R7 purged vid gone");
    lookup(12'd101, 1'b1, 10'h3FF, "R7 neighbour kept");

    bus_wr(4'h4, 32'h0000_0003);
    run_cmd(32'h012C_000A, 17, "R4 load without valid");
    lookup(12'd300, 1'b0, 10'h000, "R4 invalid data not stored");
    bus_wr(4'h4, 32'h0000_0803);
    run_cmd(32'h012C_000A, 17, "R4 load freed slot");
    lookup(12'd300, 1'b1, 10'h003, "R4 freed slot reused");

    run_cmd(32'h0000_000C, 16, "R8 remove port cycles");
    lookup(12'd5, 1'b1, 10'h110, "R8 port0 cleared vid5");
    lookup(12'd300, 1'b1, 10'h002, "R8 port0 cleared vid300");
    lookup(12'd101, 1'b1, 10'h3FE, "R8 port0 cleared vid101");
    run_cmd(32'h0000_0C0C, 16, "R8 remove port 12 cycles");
    lookup(12'd5, 1'b1, 10'h110, "R8 out of range port no effect");

    run_cmd(32'h0000_0008, 1, "R12 nop cycles");
    run_cmd(32'h0000_000E, 1, "R12 undefined op cycles");
    lookup(12'd5, 1'b1, 10'h110, "R12 table unchanged");

    bus_wr(4'h0, 32'hB003_0000);
    rd(4'h0, v); check("R1 prio fields readback", v, 32'hB003_0000);

    // flush, then a load written while busy must be dropped
    @(negedge clk); bus_we = 1'b1; bus_addr = 4'h0; bus_wdata = 32'h0000_0009;
    @(negedge clk); bus_wdata = 32'h0007_000A;
    @(negedge clk); bus_we = 1'b0;
    while (bus_rdata[3]) @(negedge clk);
    rd(4'h0, v); check("R9 busy write ignored", v, 32'h0000_0001);
    lookup(12'd7, 1'b0, 10'h000, "R9 ignored load absent");
    lookup(12'd5, 1'b0, 10'h000, "R3 flush cleared vid5");
    lookup(12'd300, 1'b0, 10'h000, "R3 flush cleared vid300");

    bus_wr(4'h4, 32'h0000_0801);
    run_cmd(32'h0009_000A, 17, "R4 load after flush");
    lookup(12'd9, 1'b1, 10'h001, "R4 load after flush");
    run_cmd(32'h0000_0009, 16, "R3 flush cycles");
    lookup(12'd9, 1'b0, 10'h000, "R3 flush cleared vid9");

    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) begin
      n_chk++; n_bad++;
      $display("FAIL R10: actual %0d pending results expected 0", exp_q.size());
    end
    report();
    $finish;
  end
endmodule